// File: doc/BRIEF.md
# Display Data Channel Segmented Read Sequencer

This block performs a complete random-address or current-address read from a display data channel target. It works by driving a separate page-based I2C master one primitive at a time. A request names the target device, a start offset, an 8- or 16-bit offset width, a byte count, a clock divider for the master, and, optionally, an E-EDID segment number. The sequencer issues the START, address-write, read-address and page-read primitives in the right order. It checks the acknowledge bitmap the master returns after every step, and it always closes the access with a STOP primitive.

Data is moved in pages of up to eight bytes. Every page except the last is read with acknowledge on every byte. The final page, holding the remaining one to eight bytes, is read with no acknowledge on its last byte. Each accepted page is streamed out one byte per clock, lowest address first. When the access finishes, a one-cycle done pulse reports how many bytes were moved and whether an error ended it. Parsing and checksumming of the data belong to the consumer of the byte stream.

Top module: `ddc_seg_reader`

## Requirements
- R1: A request with a zero count, a zero clock divider, or made while `mst_busy` is high issues no primitive and ends with a done pulse carrying count 0 and the error flag set.
- R2: Primitives are coded on `cmd_op` as 0 START, 1 WRITE, 2 page read with acknowledge, 3 page read ending without acknowledge, 4 STOP. `cmd_len` is the byte count minus one, and byte i of `cmd_wdata` sits in bits 8i+7..8i. Every access begins with START, and a new primitive is issued only after `mst_done` answers the previous one.
- R3: With segment selection on, the sequencer first writes 0x60 then the segment number (length 1) and needs acknowledge bitmap 0x03. It then issues START and uses device 0x50 in place of the requested device.
- R4: In random-address mode the sequencer writes the device address shifted left by one (bit 0 clear), then the offset. The offset is one byte, needing bitmap 0x03, or two bytes with the high byte first, needing bitmap 0x07. A START follows.
- R5: The read address byte, device shifted left by one plus one, is written alone (length 0) and needs bitmap 0x01. In current-address mode it follows the first START (or the segment START) directly, with no offset write.
- R6: Data pages hold eight bytes and use code 2 while more than eight bytes remain. The last page holds the remaining 1 to 8 bytes and uses code 3.
- R7: A page is accepted only if the run of set acknowledge bits starting at bit 0 equals the page size, or equals the page size minus one on the final page. Otherwise no byte of that page is streamed and reading stops.
- R8: Every accepted request, successful or failed, issues STOP as its last primitive. The done pulse comes only after the STOP is answered.
- R9: In random-address mode the count is clipped to the bytes left before the end of the offset space: 256 minus the low offset byte for 8-bit offsets, 65536 minus the offset for 16-bit offsets.
- R10: Each accepted page is streamed on `out_valid`/`out_data`, one byte per clock starting the cycle after the page response, byte 0 of `mst_rdata` first.
- R11: `done` is a one-cycle pulse. `done_count` equals the number of bytes streamed, and `done_err` is set exactly when an acknowledge check failed or the request was rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_dev | input | 7 | Target device address |
| req_offset | input | 16 | Start offset (low byte only in 8-bit mode) |
| req_wide | input | 1 | 1: 16-bit offset, 0: 8-bit offset |
| req_cur | input | 1 | 1: current-address read, no offset phase |
| req_seg_en | input | 1 | Write a segment pointer first |
| req_seg | input | 8 | Segment number |
| req_count | input | CNT_W | Requested byte count |
| req_clkdiv | input | DIV_W | Clock divider forwarded to the master |
| busy | output | 1 | Sequencer is handling a request |
| cmd_valid | output | 1 | One-cycle primitive strobe to the master |
| cmd_op | output | 3 | Primitive code |
| cmd_len | output | 3 | Bytes in the primitive minus one |
| cmd_wdata | output | 64 | Write bytes, byte 0 in the low bits |
| cmd_clkdiv | output | DIV_W | Clock divider for the master |
| mst_busy | input | 1 | Master reports it is busy |
| mst_done | input | 1 | Master finished the primitive |
| mst_ack | input | 8 | Acknowledge bitmap, bit i for byte i |
| mst_rdata | input | 64 | Read bytes, byte 0 in the low bits |
| out_valid | output | 1 | Read byte strobe |
| out_data | output | 8 | Read byte |
| done | output | 1 | End of request pulse |
| done_count | output | CNT_W | Bytes moved |
| done_err | output | 1 | Request failed or was rejected |

## Verification
On every cycle, the embedded properties check several things. Only one primitive is outstanding at a time. A final no-acknowledge page is issued only when at most one page remains. No page is loaded while the previous one is still draining. Every accepted request has sent STOP before done. The reported count never exceeds the clipped count, and a rejected request reports zero with an error. Only the bench's scenarios, run against a behavioural target model, can show the remaining behaviour. That covers the exact primitive order and address bytes for segment, 8-bit, 16-bit and current-address accesses, the page split, the clipping values, the byte contents and order, and the truncation point after a failed acknowledge on each kind of step.

// File: rtl/ddc_seq_pkg.sv
package ddc_seq_pkg;

  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_WRITE   = 3'd1,
    OP_RD_ACK  = 3'd2,
    OP_RD_NACK = 3'd3,
    OP_STOP    = 3'd4
  } ddc_op_e;

  typedef enum logic [2:0] {
    STP_START0,
    STP_SEGWR,
    STP_START1,
    STP_OFFWR,
    STP_START2,
    STP_DEVRD,
    STP_PAGE,
    STP_STOP
  } ddc_step_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ISSUE,
    SQ_WAIT,
    SQ_DRAIN,
    SQ_DONE
  } ddc_state_e;

  // number of consecutive set bits from bit 0, looking at lim bits
  function automatic int unsigned ack_run(input logic [31:0] a, input int unsigned lim);
    int unsigned n;
    logic        go;
    n  = 0;
    go = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (i < lim && go && a[i]) n = n + 1;
      else go = 1'b0;
    end
    return n;
  endfunction

  // clip a count against the room left in the offset space
  function automatic int unsigned clip_count(input int unsigned cnt,
                                             input int unsigned room,
                                             input logic        no_clip);
    if (no_clip || cnt <= room) return cnt;
    return room;
  endfunction

endpackage

// File: rtl/ddc_req_check.sv
module ddc_req_check
  import ddc_seq_pkg::*;
#(
  parameter int CNT_W = 17,
  parameter int DIV_W = 12
) (
  input  logic [CNT_W-1:0] count,
  input  logic [DIV_W-1:0] clkdiv,
  input  logic [15:0]      offset,
  input  logic             wide,
  input  logic             cur,
  input  logic             mst_busy,
  output logic             reject,
  output logic [CNT_W-1:0] eff_count
);

  logic [16:0] room;

  always_comb begin
    if (wide) room = 17'h10000 - {1'b0, offset};
    else      room = 17'h00100 - {9'h000, offset[7:0]};
  end

  assign reject    = (count == '0) || (clkdiv == '0) || mst_busy;
  assign eff_count = CNT_W'(clip_count(32'(count), 32'(room), cur));

endmodule

// File: rtl/ddc_ack_judge.sv
module ddc_ack_judge
  import ddc_seq_pkg::*;
#(
  parameter int PG_BYTES = 8,
  localparam int NB_W    = $clog2(PG_BYTES + 1)
) (
  input  ddc_step_e           step,
  input  logic [PG_BYTES-1:0] ack,
  input  logic                wide,
  input  logic                final_pg,
  input  logic [NB_W-1:0]     nbytes,
  output logic                pass
);

  int unsigned run;
  int unsigned need;

  always_comb begin
    run  = ack_run(32'(ack), PG_BYTES);
    need = final_pg ? 32'(nbytes) - 1 : 32'(nbytes);
    case (step)
      STP_SEGWR: pass = (ack == PG_BYTES'(8'h03));
      STP_OFFWR: pass = (ack == (wide ? PG_BYTES'(8'h07) : PG_BYTES'(8'h03)));
      STP_DEVRD: pass = (ack == PG_BYTES'(8'h01));
      STP_PAGE:  pass = (run == need);
      default:   pass = 1'b1;
    endcase
  end

endmodule

// File: rtl/ddc_byte_drain.sv
module ddc_byte_drain #(
  parameter int PG_BYTES = 8,
  localparam int PG_W    = 8 * PG_BYTES,
  localparam int NB_W    = $clog2(PG_BYTES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PG_W-1:0] page_in,
  input  logic [NB_W-1:0] nbytes,
  output logic            out_valid,
  output logic [7:0]      out_data,
  output logic            last,
  output logic            idle
);

  logic [PG_W-1:0] sh_q;
  logic [NB_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load) begin
      sh_q   <= page_in;
      left_q <= nbytes;
    end else if (left_q != '0) begin
      sh_q   <= sh_q >> 8;
      left_q <= left_q - 1'b1;
    end
  end

  assign out_valid = (left_q != '0);
  assign out_data  = sh_q[7:0];
  assign last      = (left_q == NB_W'(1));
  assign idle      = (left_q == '0);

  // R10
  drain_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> idle);

  // R10
  drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !last && !load) |=> out_valid);

endmodule

// File: rtl/ddc_seg_reader.sv
module ddc_seg_reader
  import ddc_seq_pkg::*;
#(
  parameter int          CNT_W    = 17,
  parameter int          DIV_W    = 12,
  parameter int          PG_BYTES = 8,
  parameter logic [6:0]  EDID_DEV = 7'h50,
  parameter logic [7:0]  SEG_BYTE = 8'h60,
  localparam int         PG_W     = 8 * PG_BYTES,
  localparam int         LEN_W    = $clog2(PG_BYTES),
  localparam int         NB_W     = $clog2(PG_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [6:0]        req_dev,
  input  logic [15:0]       req_offset,
  input  logic              req_wide,
  input  logic              req_cur,
  input  logic              req_seg_en,
  input  logic [7:0]        req_seg,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [DIV_W-1:0]  req_clkdiv,
  output logic              busy,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [LEN_W-1:0]  cmd_len,
  output logic [PG_W-1:0]   cmd_wdata,
  output logic [DIV_W-1:0]  cmd_clkdiv,
  input  logic              mst_busy,
  input  logic              mst_done,
  input  logic [PG_BYTES-1:0] mst_ack,
  input  logic [PG_W-1:0]   mst_rdata,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              done,
  output logic [CNT_W-1:0]  done_count,
  output logic              done_err
);

  ddc_state_e       state_q;
  ddc_step_e        step_q;
  logic [6:0]       dev_q;
  logic [15:0]      off_q;
  logic             wide_q, cur_q, seg_en_q, rej_q, err_q, stop_sent_q;
  logic [7:0]       seg_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] rem_q, cnt_q, eff_q;

  // named internal events
  logic             req_take;
  logic             req_reject;
  logic [CNT_W-1:0] req_eff;
  logic             rsp_take;
  logic             step_pass;
  logic             page_load;
  logic             final_pg;
  logic [NB_W-1:0]  pg_n;
  logic [6:0]       dev_eff;
  logic             drain_last, drain_idle;

  assign req_take = (state_q == SQ_IDLE) && req_valid;
  assign rsp_take = (state_q == SQ_WAIT) && mst_done;

  ddc_req_check #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_check (
    .count     (req_count),
    .clkdiv    (req_clkdiv),
    .offset    (req_offset),
    .wide      (req_wide),
    .cur       (req_cur),
    .mst_busy  (mst_busy),
    .reject    (req_reject),
    .eff_count (req_eff)
  );

  assign final_pg = (rem_q <= CNT_W'(PG_BYTES));
  assign pg_n     = final_pg ? rem_q[NB_W-1:0] : NB_W'(PG_BYTES);
  assign dev_eff  = seg_en_q ? EDID_DEV : dev_q;

  ddc_ack_judge #(.PG_BYTES(PG_BYTES)) u_judge (
    .step     (step_q),
    .ack      (mst_ack),
    .wide     (wide_q),
    .final_pg (final_pg),
    .nbytes   (pg_n),
    .pass     (step_pass)
  );

  assign page_load = rsp_take && (step_q == STP_PAGE) && step_pass;

  ddc_byte_drain #(.PG_BYTES(PG_BYTES)) u_drain (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (page_load),
    .page_in   (mst_rdata),
    .nbytes    (pg_n),
    .out_valid (out_valid),
    .out_data  (out_data),
    .last      (drain_last),
    .idle      (drain_idle)
  );

  // primitive builder
  always_comb begin
    cmd_op    = OP_START;
    cmd_len   = '0;
    cmd_wdata = '0;
    case (step_q)
      STP_SEGWR: begin
        cmd_op          = OP_WRITE;
        cmd_len         = LEN_W'(1);
        cmd_wdata[7:0]  = SEG_BYTE;
        cmd_wdata[15:8] = seg_q;
      end
      STP_OFFWR: begin
        cmd_op         = OP_WRITE;
        cmd_wdata[7:0] = {dev_eff, 1'b0};
        if (wide_q) begin
          cmd_len          = LEN_W'(2);
          cmd_wdata[15:8]  = off_q[15:8];
          cmd_wdata[23:16] = off_q[7:0];
        end else begin
          cmd_len         = LEN_W'(1);
          cmd_wdata[15:8] = off_q[7:0];
        end
      end
      STP_DEVRD: begin
        cmd_op         = OP_WRITE;
        cmd_wdata[7:0] = {dev_eff, 1'b1};
      end
      STP_PAGE: begin
        cmd_op  = final_pg ? OP_RD_NACK : OP_RD_ACK;
        cmd_len = LEN_W'(pg_n - 1'b1);
      end
      STP_STOP: cmd_op = OP_STOP;
      default:  cmd_op = OP_START;
    endcase
  end

  assign cmd_valid  = (state_q == SQ_ISSUE);
  assign cmd_clkdiv = div_q;
  assign busy       = (state_q != SQ_IDLE);
  assign done       = (state_q == SQ_DONE);
  assign done_count = cnt_q;
  assign done_err   = err_q;

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SQ_IDLE;
      step_q      <= STP_START0;
      dev_q       <= '0;
      off_q       <= '0;
      wide_q      <= 1'b0;
      cur_q       <= 1'b0;
      seg_en_q    <= 1'b0;
      seg_q       <= '0;
      div_q       <= '0;
      rem_q       <= '0;
      cnt_q       <= '0;
      eff_q       <= '0;
      rej_q       <= 1'b0;
      err_q       <= 1'b0;
      stop_sent_q <= 1'b0;
    end else begin
      if (cmd_valid && cmd_op == OP_STOP) stop_sent_q <= 1'b1;
      case (state_q)
        SQ_IDLE: if (req_take) begin
          dev_q       <= req_dev;
          off_q       <= req_offset;
          wide_q      <= req_wide;
          cur_q       <= req_cur;
          seg_en_q    <= req_seg_en;
          seg_q       <= req_seg;
          div_q       <= req_clkdiv;
          rem_q       <= req_eff;
          eff_q       <= req_reject ? '0 : req_eff;
          cnt_q       <= '0;
          rej_q       <= req_reject;
          err_q       <= req_reject;
          stop_sent_q <= 1'b0;
          step_q      <= STP_START0;
          state_q     <= req_reject ? SQ_DONE : SQ_ISSUE;
        end
        SQ_ISSUE: state_q <= SQ_WAIT;
        SQ_WAIT: if (mst_done) begin
          state_q <= SQ_ISSUE;
          case (step_q)
            STP_START0: step_q <= seg_en_q ? STP_SEGWR : (cur_q ? STP_DEVRD : STP_OFFWR);
            STP_START1: step_q <= cur_q ? STP_DEVRD : STP_OFFWR;
            STP_START2: step_q <= STP_DEVRD;
            STP_SEGWR:  step_q <= step_pass ? STP_START1 : STP_STOP;
            STP_OFFWR:  step_q <= step_pass ? STP_START2 : STP_STOP;
            STP_DEVRD:  step_q <= step_pass ? STP_PAGE : STP_STOP;
            STP_PAGE: begin
              if (step_pass) begin
                state_q <= SQ_DRAIN;
                rem_q   <= rem_q - CNT_W'(pg_n);
                cnt_q   <= cnt_q + CNT_W'(pg_n);
              end else begin
                step_q <= STP_STOP;
              end
            end
            default: state_q <= SQ_DONE;
          endcase
          if (!step_pass) err_q <= 1'b1;
        end
        SQ_DRAIN: if (drain_last) begin
          state_q <= SQ_ISSUE;
          step_q  <= (rem_q == '0) ? STP_STOP : STP_PAGE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // R2
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R6
  nack_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_RD_NACK) |-> (rem_q <= CNT_W'(PG_BYTES)));

  // R8
  stop_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rej_q) |-> stop_sent_q);

  // R11
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_count <= eff_q));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rej_q) |-> (done_err && done_count == '0 && !stop_sent_q));

endmodule

// File: tb/ddc_seg_reader_test.sv
module ddc_seg_reader_test;

  localparam int CNT_W = 17;
  localparam int DIV_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [6:0]        req_dev = '0;
  logic [15:0]       req_offset = '0;
  logic              req_wide = 1'b0, req_cur = 1'b0, req_seg_en = 1'b0;
  logic [7:0]        req_seg = '0;
  logic [CNT_W-1:0]  req_count = '0;
  logic [DIV_W-1:0]  req_clkdiv = '0;
  logic              busy, cmd_valid;
  logic [2:0]        cmd_op, cmd_len;
  logic [63:0]       cmd_wdata;
  logic [DIV_W-1:0]  cmd_clkdiv;
  logic              mst_busy = 1'b0, mst_done = 1'b0;
  logic [7:0]        mst_ack = '0;
  logic [63:0]       mst_rdata = '0;
  logic              out_valid, done, done_err;
  logic [7:0]        out_data;
  logic [CNT_W-1:0]  done_count;

  always #5 clk = ~clk;

  ddc_seg_reader uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dev(req_dev),
    .req_offset(req_offset), .req_wide(req_wide), .req_cur(req_cur),
    .req_seg_en(req_seg_en), .req_seg(req_seg), .req_count(req_count),
    .req_clkdiv(req_clkdiv), .busy(busy), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_len(cmd_len), .cmd_wdata(cmd_wdata),
    .cmd_clkdiv(cmd_clkdiv), .mst_busy(mst_busy), .mst_done(mst_done),
    .mst_ack(mst_ack), .mst_rdata(mst_rdata), .out_valid(out_valid),
    .out_data(out_data), .done(done), .done_count(done_count),
    .done_err(done_err)
  );

  typedef struct {
    int    op;
    int    len;
    logic [63:0] wd;
    string tag;
  } exp_cmd_t;

  exp_cmd_t    cq[$];
  logic [7:0]  bq[$];
  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  // behavioural target model state
  int m_ptr = 0;
  int m_seg = 0;
  int fail_at = -1;
  int prim_no = 0;
  int lat = 0;
  logic [7:0]  r_ack;
  logic [63:0] r_data;

  function automatic logic [7:0] memv(input int s, input int a);
    return 8'((a * 7) + ((a >> 8) * 3) + (s * 29) + 5);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic add(input int op, input int len, input logic [63:0] wd, input string tag);
    exp_cmd_t e;
    e.op = op; e.len = len; e.wd = wd; e.tag = tag;
    cq.push_back(e);
  endtask

  // master + target model and output monitor
  always @(negedge clk) begin
    mst_done <= 1'b0;
    if (lat == 1) begin
      mst_done  <= 1'b1;
      mst_ack   <= r_ack;
      mst_rdata <= r_data;
    end
    if (lat > 0) lat--;
    if (out_valid) begin
      if (bq.size() == 0) check(1'b0, "R10", "unexpected byte", out_data, 0);
      else begin
        logic [7:0] eb;
        eb = bq.pop_front();
        check(out_data == eb, "R10", "stream byte", out_data, eb);
      end
    end
    if (cmd_valid) begin
      int idx;
      int nrm;
      idx = prim_no;
      prim_no++;
      if (cq.size() == 0) check(1'b0, "R2", "unexpected primitive", cmd_op, 7);
      else begin
        exp_cmd_t e;
        e = cq.pop_front();
        check(int'(cmd_op) == e.op, e.tag, "primitive code", cmd_op, e.op);
        check(int'(cmd_len) == e.len, e.tag, "primitive length", cmd_len, e.len);
        if (e.op == 1) begin
          logic [63:0] m;
          m = (64'h1 << (8 * (e.len + 1))) - 1;
          check((cmd_wdata & m) == e.wd, e.tag, "write bytes", cmd_wdata & m, e.wd);
        end
      end
      r_data = '0;
      case (int'(cmd_op))
        1, 2:    nrm = (1 << (int'(cmd_len) + 1)) - 1;
        3:       nrm = (1 << int'(cmd_len)) - 1;
        default: nrm = 0;
      endcase
      if (idx == fail_at) r_ack = (nrm == 255) ? 8'h7F : 8'hFF;
      else begin
        r_ack = 8'(nrm);
        if (cmd_op == 3'd1) begin
          if (cmd_wdata[7:0] == 8'h60) m_seg = int'(cmd_wdata[15:8]);
          else if (!cmd_wdata[0] && cmd_len == 3'd2) m_ptr = int'({cmd_wdata[15:8], cmd_wdata[23:16]});
          else if (!cmd_wdata[0] && cmd_len == 3'd1) m_ptr = int'(cmd_wdata[15:8]);
        end else if (cmd_op == 3'd2 || cmd_op == 3'd3) begin
          for (int i = 0; i <= int'(cmd_len); i++)
            r_data[8*i +: 8] = memv(m_seg, (m_ptr + i) & 16'hFFFF);
          m_ptr = (m_ptr + int'(cmd_len) + 1) & 16'hFFFF;
        end
      end
      lat = 3;
    end
  end

  task automatic run_case(input logic [6:0] dev, input int off, input bit wide,
                          input bit cur, input bit segen, input int seg,
                          input int cnt, input int div, input bit bsy,
                          input int fidx, input string tag);
    int eff, d, rem, n, p, s, pre, ecnt, pg, w;
    bit rej, eerr;
    rej  = (cnt == 0) || (div == 0) || bsy;
    eff  = cnt;
    if (!cur) begin
      int room;
      room = wide ? 65536 - off : 256 - (off & 255);
      if (eff > room) eff = room;
    end
    d    = segen ? 'h50 : int'(dev);
    p    = cur ? m_ptr : (wide ? off : (off & 255));
    s    = segen ? seg : m_seg;
    pre  = 1 + (segen ? 2 : 0) + (cur ? 0 : 2) + 1;
    ecnt = 0;
    eerr = rej || (fidx >= 0);
    cq.delete();
    bq.delete();
    if (!rej) begin
      add(0, 0, 0, "R2");
      if (segen) begin
        add(1, 1, {48'h0, 8'(seg), 8'h60}, "R3");
        add(0, 0, 0, "R3");
      end
      if (!cur) begin
        if (wide) add(1, 2, {40'h0, 8'(off), 8'(off >> 8), 7'(d), 1'b0}, "R4");
        else      add(1, 1, {48'h0, 8'(off), 7'(d), 1'b0}, "R4");
        add(0, 0, 0, "R4");
      end
      add(1, 0, {56'h0, 7'(d), 1'b1}, "R5");
      rem = eff;
      pg  = 0;
      while (rem > 0) begin
        n = (rem > 8) ? 8 : rem;
        add((rem > 8) ? 2 : 3, n - 1, 0, "R6");
        if (fidx < 0 || pre + pg < fidx) begin
          for (int i = 0; i < n; i++) bq.push_back(memv(s, (p + ecnt + i) & 16'hFFFF));
          ecnt += n;
        end
        rem -= n;
        pg++;
      end
      add(4, 0, 0, "R8");
      if (fidx >= 0) begin
        while (cq.size() > fidx + 1) void'(cq.pop_back());
        add(4, 0, 0, "R8");
      end
    end
    fail_at = fidx;
    prim_no = 0;
    @(negedge clk);
    req_dev = dev; req_offset = 16'(off); req_wide = wide; req_cur = cur;
    req_seg_en = segen; req_seg = 8'(seg); req_count = CNT_W'(cnt);
    req_clkdiv = DIV_W'(div); mst_busy = bsy; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    while (!done && w < 3000) begin
      @(negedge clk);
      w++;
    end
    mst_busy = 1'b0;
    check(done == 1'b1, tag, "done seen", done, 1);
    check(int'(done_count) == ecnt, tag, "done count", done_count, ecnt);
    check(done_err == eerr, "R11", "error flag", done_err, eerr);
    check(cq.size() == 0, "R8", "primitives left", cq.size(), 0);
    check(bq.size() == 0, "R10", "bytes left", bq.size(), 0);
    @(negedge clk);
    check(!done && !busy, "R11", "done single pulse", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !cmd_valid && !out_valid, "R2", "reset state",
          {busy, done, cmd_valid, out_valid}, 0);
    run_case(7'h50, 'h10,   0, 0, 0, 0, 20, 4, 0, -1, "R6");
    run_case(7'h3A, 'h1234, 1, 0, 0, 0, 8,  4, 0, -1, "R4");
    run_case(7'h11, 'h80,   0, 0, 1, 1, 9,  4, 0, -1, "R3");
    run_case(7'h50, 'hFA,   0, 0, 0, 0, 20, 4, 0, -1, "R9");
    run_case(7'h50, 'hFFFE, 1, 0, 0, 0, 5,  4, 0, -1, "R9");
    run_case(7'h50, 0,      0, 1, 0, 0, 3,  4, 0, -1, "R5");
    run_case(7'h50, 'h40,   0, 0, 0, 0, 16, 4, 0, -1, "R6");
    run_case(7'h50, 'h40,   0, 1, 1, 2, 10, 4, 0, -1, "R3");
    run_case(7'h50, 'h20,   0, 0, 1, 3, 8,  4, 0, 1,  "R3");
    run_case(7'h50, 'h20,   0, 0, 0, 0, 8,  4, 0, 1,  "R4");
    run_case(7'h50, 'h20,   1, 0, 0, 0, 8,  4, 0, 3,  "R5");
    run_case(7'h50, 'h20,   0, 0, 0, 0, 20, 4, 0, 5,  "R7");
    run_case(7'h50, 'h20,   0, 0, 0, 0, 9,  4, 0, 5,  "R7");
    run_case(7'h50, 'h20,   0, 0, 0, 0, 0,  4, 0, -1, "R1");
    run_case(7'h50, 'h20,   0, 0, 0, 0, 5,  0, 0, -1, "R1");
    run_case(7'h50, 'h20,   0, 0, 0, 0, 5,  4, 1, -1, "R1");
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule